// File: doc/BRIEF.md
# Register and Stage-Counter ALU

This block carries out the arithmetic/logic instruction class of a small coprocessor. The coprocessor has four 16-bit general registers and one 8-bit stage counter. One instruction class covers three forms. The register form combines two registers. The immediate form uses a 16-bit constant in place of the second register. The stage form increments, decrements or clears the stage counter. The results of register operations also set a zero flag and an overflow flag, which a branch unit tests later for its equal and overflow jumps.

The register file sits outside the block. The block drives two read addresses from the instruction word and reads the operand data combinationally. In the same cycle as the valid instruction it drives a write strobe, an address and data, so the register file captures the result on that clock edge. The stage counter, both flags and the illegal-instruction pulse are registers inside the block. They update on that same edge.

Top module: `regstage_alu`

## Requirements
- R1: While reset is held (synchronous, active low), and on the first cycle after it, the stage counter is 0, both flags are 0, `illegal_o` is 0 and `rf_wr_en` is 0.
- R2: The block acts only when `instr_valid` is high and bits 31:28 of the word equal 7. Any other word, or a word without valid, writes no register and changes neither the counter nor the flags. It does not raise `illegal_o`.
- R3: Bits 27:25 select the form: 0 is register, 1 is immediate, 2 is stage. Form values 3 to 7 are illegal.
- R4: In register form, the destination is bits 1:0, source 1 is bits 3:2 and source 2 is bits 5:4. The operation is bits 24:21: 0 add, 1 subtract, 2 and, 3 or, 4 move, 5 shift left, 6 shift right. The write is strobed during the instruction's valid cycle.
- R5: In immediate form, the 16-bit value in bits 19:4 takes the place of source 2. Move loads that value into the destination.
- R6: Add and subtract wrap modulo 2^16. The overflow flag takes the carry out of an add, or the borrow of a subtract (set when source 1 is less than the second operand).
- R7: And and or are bitwise. A register-form move copies source 1 and ignores source 2.
- R8: Shifts use only the low 4 bits of the second operand as the amount, and fill the vacated bits with zeros.
- R9: Every register write sets the zero flag when the written value is 0 and clears it otherwise. A write by any operation other than add or subtract clears the overflow flag.
- R10: In stage form, the 8-bit value in bits 11:4 is added to the counter by operation 0 and subtracted by operation 1, with wrap-around modulo 256. Operation 2 clears the counter. Stage operations write no register and leave both flags unchanged.
- R11: An illegal form, a register or immediate operation code of 7 to 15, or a stage operation code of 3 to 15 writes nothing and leaves the counter and flags unchanged. `illegal_o` is high for exactly the one cycle after that instruction's valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| rf_rd_addr_a | output | 2 | Register-file read address for source 1 |
| rf_rd_addr_b | output | 2 | Register-file read address for source 2 |
| rf_rd_data_a | input | 16 | Source 1 data |
| rf_rd_data_b | input | 16 | Source 2 data |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_addr | output | 2 | Register write address |
| rf_wr_data | output | 16 | Register write data |
| stage_cnt | output | 8 | Stage counter value |
| flag_zero | output | 1 | Last register result was zero |
| flag_ovf | output | 1 | Carry or borrow of the last register add or subtract |
| illegal_o | output | 1 | One-cycle pulse after an illegal instruction of this class |

## Verification
The bench targets carry and borrow at the 16-bit edge, because a design that kept a 17th bit or inverted the borrow would give the wrong overflow flag for a jump. It shifts by amounts above 15, where a design that used the full amount would zero or garble the result. It also wraps the stage counter in both directions and confirms that stage operations leave the flags as they were, which a design that shared flag logic with register writes would break. Illegal forms and codes, foreign opcodes and invalid strobes must leave registers, counter and flags untouched, and the illegal pulse must last exactly one cycle rather than sticking or firing on words from other classes.

// File: rtl/ralu_pkg.sv
// Package: encoding constants and the decoded-instruction record shared by
// the ALU decoder, datapath, stage counter and top level.
// Assumes the fixed 32-bit instruction layout; field widths are set by it.
package ralu_pkg;

    localparam logic [3:0] OPC_ALU   = 4'd7;
    localparam logic [2:0] FORM_REG  = 3'd0;
    localparam logic [2:0] FORM_IMM  = 3'd1;
    localparam logic [2:0] FORM_STG  = 3'd2;
    localparam int         IMM_W     = 16;
    localparam int         STG_IMM_W = 8;
    localparam int         RIDX_W    = 2;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_MOV = 4'd4,
        OP_LSH = 4'd5,
        OP_RSH = 4'd6
    } alu_op_e;

    localparam logic [3:0] STG_INC = 4'd0;
    localparam logic [3:0] STG_DEC = 4'd1;
    localparam logic [3:0] STG_CLR = 4'd2;

    typedef struct packed {
        logic                 exec_reg;
        logic                 exec_stage;
        logic                 illegal;
        logic                 use_imm;
        logic [3:0]           sel;
        logic [RIDX_W-1:0]    dst;
        logic [RIDX_W-1:0]    src1;
        logic [RIDX_W-1:0]    src2;
        logic [IMM_W-1:0]     imm;
        logic [STG_IMM_W-1:0] stg_imm;
    } ralu_dec_t;

endpackage

// File: rtl/ralu_decode.sv
// Decoder: splits an instruction word into fields and classifies it as a
// register-writing operation, a stage operation, an illegal word of this
// class, or a word for some other unit (all outcomes low).
// Assumes: purely combinational; the caller registers whatever it needs.
module ralu_decode
    import ralu_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] word_i,
    output ralu_dec_t   dec_o
);

    logic       hit;
    logic       legal;
    logic [2:0] form;
    logic [3:0] sel;
    logic       unused_bit20;

    assign form         = word_i[27:25];
    assign sel          = word_i[24:21];
    assign hit          = valid_i && (word_i[31:28] == OPC_ALU);
    assign unused_bit20 = word_i[20];

    // Legality of the operation code within the selected form.
    always_comb begin
        case (form)
            FORM_REG, FORM_IMM: legal = (sel <= 4'd6);
            FORM_STG:           legal = (sel <= STG_CLR);
            default:            legal = 1'b0;
        endcase
    end

    // Assemble the decoded record.
    always_comb begin
        dec_o            = '0;
        dec_o.exec_reg   = hit && legal && (form != FORM_STG);
        dec_o.exec_stage = hit && legal && (form == FORM_STG);
        dec_o.illegal    = hit && !legal;
        dec_o.use_imm    = (form == FORM_IMM);
        dec_o.sel        = sel;
        dec_o.dst        = word_i[1:0];
        dec_o.src1       = word_i[3:2];
        dec_o.src2       = word_i[5:4];
        dec_o.imm        = word_i[19:4];
        dec_o.stg_imm    = word_i[11:4];
    end

    // An instruction has at most one outcome.
    always_comb begin
        assert_one_outcome_R11: assert ($countones({dec_o.exec_reg, dec_o.exec_stage, dec_o.illegal}) <= 1)
            else $error("decoder produced more than one outcome");
    end

endmodule

// File: rtl/ralu_exec.sv
// Datapath: computes the register result of one legal register/immediate
// operation, its carry or borrow, and whether the operation is add/subtract.
// Assumes the operation code is legal when the result is used.
module ralu_exec
    import ralu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              use_imm_i,
    input  logic [3:0]        sel_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              addsub_o
);

    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] opb;
    logic [DATA_W:0]   sum;
    logic [DATA_W:0]   diff;
    logic [SH_W-1:0]   shamt;

    assign opb   = use_imm_i ? DATA_W'(imm_i) : b_i;
    assign sum   = {1'b0, a_i} + {1'b0, opb};
    assign diff  = {1'b0, a_i} - {1'b0, opb};
    assign shamt = opb[SH_W-1:0];

    // Select the result and the carry/borrow of the chosen operation.
    always_comb begin
        result_o = '0;
        carry_o  = 1'b0;
        addsub_o = 1'b0;
        case (alu_op_e'(sel_i))
            OP_ADD: begin result_o = sum[DATA_W-1:0];  carry_o = sum[DATA_W];  addsub_o = 1'b1; end
            OP_SUB: begin result_o = diff[DATA_W-1:0]; carry_o = diff[DATA_W]; addsub_o = 1'b1; end
            OP_AND: result_o = a_i & opb;
            OP_OR:  result_o = a_i | opb;
            OP_MOV: result_o = use_imm_i ? opb : a_i;
            OP_LSH: result_o = a_i << shamt;
            OP_RSH: result_o = a_i >> shamt;
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/ralu_stage.sv
// Stage counter: a wrapping counter that is incremented, decremented by an
// 8-bit step, or cleared, by a legal stage-form instruction.
// Assumes en_i is only high for a legal stage operation code.
module ralu_stage
    import ralu_pkg::*;
#(
    parameter int STAGE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [3:0]           sel_i,
    input  logic [STG_IMM_W-1:0] step_i,
    output logic [STAGE_W-1:0]   cnt_o
);

    logic [STAGE_W-1:0] step;
    assign step = STAGE_W'(step_i);

    // Counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (en_i) begin
            case (sel_i)
                STG_INC: cnt_o <= cnt_o + step;
                STG_DEC: cnt_o <= cnt_o - step;
                default: cnt_o <= '0;
            endcase
        end
    end

    assert_stage_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sel_i == STG_CLR) |=> (cnt_o == '0))
        else $error("stage counter not cleared");

    assert_stage_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_o))
        else $error("stage counter moved without a stage operation");

endmodule

// File: rtl/regstage_alu.sv
// Top: executes the ALU instruction class. It drives register-file read
// addresses, strobes the result write in the instruction's valid cycle,
// and holds the stage counter, zero/overflow flags and illegal pulse.
// Assumes an external register file with combinational read and a write
// captured on the clock edge that ends the valid cycle.
module regstage_alu
    import ralu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int STAGE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [31:0]        instr_word,
    output logic [1:0]         rf_rd_addr_a,
    output logic [1:0]         rf_rd_addr_b,
    input  logic [DATA_W-1:0]  rf_rd_data_a,
    input  logic [DATA_W-1:0]  rf_rd_data_b,
    output logic               rf_wr_en,
    output logic [1:0]         rf_wr_addr,
    output logic [DATA_W-1:0]  rf_wr_data,
    output logic [STAGE_W-1:0] stage_cnt,
    output logic               flag_zero,
    output logic               flag_ovf,
    output logic               illegal_o
);

    ralu_dec_t         dec;
    logic [DATA_W-1:0] result;
    logic              carry;
    logic              addsub;

    ralu_decode u_decode (
        .valid_i (instr_valid),
        .word_i  (instr_word),
        .dec_o   (dec)
    );

    ralu_exec #(.DATA_W(DATA_W)) u_exec (
        .use_imm_i (dec.use_imm),
        .sel_i     (dec.sel),
        .a_i       (rf_rd_data_a),
        .b_i       (rf_rd_data_b),
        .imm_i     (dec.imm),
        .result_o  (result),
        .carry_o   (carry),
        .addsub_o  (addsub)
    );

    ralu_stage #(.STAGE_W(STAGE_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (dec.exec_stage),
        .sel_i  (dec.sel),
        .step_i (dec.stg_imm),
        .cnt_o  (stage_cnt)
    );

    assign rf_rd_addr_a = dec.src1;
    assign rf_rd_addr_b = dec.src2;
    assign rf_wr_en     = dec.exec_reg;
    assign rf_wr_addr   = dec.dst;
    assign rf_wr_data   = result;

    // Flags follow register writes; the illegal pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_zero <= 1'b0;
            flag_ovf  <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            illegal_o <= dec.illegal;
            if (dec.exec_reg) begin
                flag_zero <= (result == '0);
                flag_ovf  <= addsub && carry;
            end
        end
    end

    assert_wr_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (instr_valid && instr_word[31:28] == OPC_ALU))
        else $error("register write without an ALU instruction");

    assert_ovf_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && !addsub) |=> !flag_ovf)
        else $error("overflow not cleared by non-arithmetic write");

    assert_zero_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> (flag_zero == ($past(rf_wr_data) == '0)))
        else $error("zero flag does not match written value");

    assert_illegal_keeps_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($stable(flag_zero) && $stable(flag_ovf)))
        else $error("flags moved on an illegal instruction");

endmodule

// File: tb/regstage_alu_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module regstage_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [1:0]  rf_rd_addr_a, rf_rd_addr_b, rf_wr_addr;
    logic [15:0] rf_rd_data_a, rf_rd_data_b, rf_wr_data;
    logic        rf_wr_en;
    logic [7:0]  stage_cnt;
    logic        flag_zero, flag_ovf, illegal_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] rf [4];
    logic [15:0] exp_r [4];

    always #5 clk = ~clk;

    regstage_alu dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_word   (instr_word),
        .rf_rd_addr_a (rf_rd_addr_a),
        .rf_rd_addr_b (rf_rd_addr_b),
        .rf_rd_data_a (rf_rd_data_a),
        .rf_rd_data_b (rf_rd_data_b),
        .rf_wr_en     (rf_wr_en),
        .rf_wr_addr   (rf_wr_addr),
        .rf_wr_data   (rf_wr_data),
        .stage_cnt    (stage_cnt),
        .flag_zero    (flag_zero),
        .flag_ovf     (flag_ovf),
        .illegal_o    (illegal_o)
    );

    // Bench register file.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) rf[i] <= '0;
        end else if (rf_wr_en) begin
            rf[rf_wr_addr] <= rf_wr_data;
        end
    end
    assign rf_rd_data_a = rf[rf_rd_addr_a];
    assign rf_rd_data_b = rf[rf_rd_addr_b];

    function automatic logic [31:0] w_reg(input logic [3:0] op, input logic [1:0] d,
                                          input logic [1:0] s1, input logic [1:0] s2);
        return {4'd7, 3'd0, op, 15'd0, s2, s1, d};
    endfunction

    function automatic logic [31:0] w_imm(input logic [3:0] op, input logic [1:0] d,
                                          input logic [1:0] s1, input logic [15:0] v);
        return {4'd7, 3'd1, op, 1'b0, v, s1, d};
    endfunction

    function automatic logic [31:0] w_stg(input logic [3:0] op, input logic [7:0] v);
        return {4'd7, 3'd2, op, 9'd0, v, 4'd0};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_rf(input string tag);
        for (int i = 0; i < 4; i++) chk(tag, rf[i], exp_r[i]);
    endtask

    // Present one word for one cycle; return at the following falling edge.
    task automatic issue(input logic v, input logic [31:0] w);
        @(negedge clk);
        instr_valid = v;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = '0;
    endtask

    task automatic t_reset;
        chk("R1 stage", 16'(stage_cnt), 16'h0);
        chk("R1 zero", 16'(flag_zero), 16'h0);
        chk("R1 ovf", 16'(flag_ovf), 16'h0);
        chk("R1 illegal", 16'(illegal_o), 16'h0);
        chk("R1 wr_en", 16'(rf_wr_en), 16'h0);
        for (int i = 0; i < 4; i++) exp_r[i] = '0;
    endtask

    task automatic t_arith;
        issue(1, w_imm(4, 0, 3, 16'h1234)); exp_r[0] = 16'h1234;
        chk_rf("R5 move imm");
        issue(1, w_imm(4, 1, 0, 16'hFFFF)); exp_r[1] = 16'hFFFF;
        chk_rf("R5 move imm");
        issue(1, w_reg(0, 2, 0, 1)); exp_r[2] = 16'h1233;
        chk_rf("R4 R6 add reg");
        chk("R6 add carry", 16'(flag_ovf), 16'h1);
        chk("R9 zero", 16'(flag_zero), 16'h0);
        issue(1, w_imm(0, 3, 1, 16'h0001)); exp_r[3] = 16'h0000;
        chk_rf("R6 add imm wrap");
        chk("R9 zero set", 16'(flag_zero), 16'h1);
        chk("R6 carry", 16'(flag_ovf), 16'h1);
        issue(1, w_reg(1, 2, 0, 1)); exp_r[2] = 16'h1235;
        chk_rf("R6 sub borrow");
        chk("R6 borrow", 16'(flag_ovf), 16'h1);
        issue(1, w_imm(1, 3, 0, 16'h1234)); exp_r[3] = 16'h0000;
        chk_rf("R6 sub imm");
        chk("R6 no borrow", 16'(flag_ovf), 16'h0);
        chk("R9 zero sub", 16'(flag_zero), 16'h1);
    endtask

    task automatic t_logic;
        issue(1, w_reg(0, 3, 1, 1)); exp_r[3] = 16'hFFFE;
        chk("R6 carry before and", 16'(flag_ovf), 16'h1);
        issue(1, w_reg(2, 2, 0, 3)); exp_r[2] = 16'h1234;
        chk_rf("R7 and reg");
        chk("R9 ovf cleared", 16'(flag_ovf), 16'h0);
        issue(1, w_imm(3, 2, 0, 16'h00C3)); exp_r[2] = 16'h12F7;
        chk_rf("R7 or imm");
        issue(1, w_reg(4, 3, 0, 1)); exp_r[3] = 16'h1234;
        chk_rf("R7 move reg");
        issue(1, w_imm(2, 2, 0, 16'h0000)); exp_r[2] = 16'h0000;
        chk_rf("R7 and imm zero");
        chk("R9 zero and", 16'(flag_zero), 16'h1);
    endtask

    task automatic t_shift;
        issue(1, w_imm(4, 1, 0, 16'h0013)); exp_r[1] = 16'h0013;
        issue(1, w_reg(5, 2, 0, 1)); exp_r[2] = 16'h91A0;
        chk_rf("R8 lsh amount low bits");
        chk("R9 zero lsh", 16'(flag_zero), 16'h0);
        issue(1, w_imm(6, 2, 0, 16'h0014)); exp_r[2] = 16'h0123;
        chk_rf("R8 rsh imm");
        issue(1, w_imm(5, 2, 0, 16'h000F)); exp_r[2] = 16'h0000;
        chk_rf("R8 lsh zero fill");
        chk("R9 zero shift", 16'(flag_zero), 16'h1);
        issue(1, w_imm(6, 2, 0, 16'h0010)); exp_r[2] = 16'h1234;
        chk_rf("R8 shift by 16 is 0");
    endtask

    task automatic t_stage;
        logic z, v;
        issue(1, w_reg(0, 3, 1, 1)); exp_r[3] = 16'h0026;
        z = flag_zero; v = flag_ovf;
        issue(1, w_stg(0, 8'h05));
        chk("R10 inc", 16'(stage_cnt), 16'h0005);
        issue(1, w_stg(0, 8'hFF));
        chk("R10 inc wrap", 16'(stage_cnt), 16'h0004);
        issue(1, w_stg(1, 8'h0A));
        chk("R10 dec wrap", 16'(stage_cnt), 16'h00FA);
        chk("R10 zero kept", 16'(flag_zero), 16'(z));
        chk("R10 ovf kept", 16'(flag_ovf), 16'(v));
        chk_rf("R10 no reg write");
        issue(1, w_stg(2, 8'h33));
        chk("R10 clear", 16'(stage_cnt), 16'h0000);
    endtask

    task automatic t_illegal;
        logic z, v;
        issue(1, w_stg(0, 8'h07));
        issue(1, w_imm(1, 0, 0, 16'h1235)); exp_r[0] = 16'hFFFF;
        z = flag_zero; v = flag_ovf;
        chk("R6 setup borrow", 16'(v), 16'h1);
        issue(1, {4'd7, 3'd3, 4'd0, 15'd0, 2'd1, 2'd1, 2'd2});
        chk("R3 form 3 illegal", 16'(illegal_o), 16'h1);
        chk_rf("R3 form 3 no write");
        @(negedge clk);
        chk("R11 pulse one cycle", 16'(illegal_o), 16'h0);
        issue(1, w_reg(7, 2, 0, 0));
        chk("R11 reg op 7", 16'(illegal_o), 16'h1);
        chk_rf("R11 reg op 7 no write");
        issue(1, w_imm(15, 2, 0, 16'h0000));
        chk("R11 imm op 15", 16'(illegal_o), 16'h1);
        chk_rf("R11 imm op 15 no write");
        issue(1, w_stg(3, 8'h01));
        chk("R11 stage op 3", 16'(illegal_o), 16'h1);
        chk("R11 stage kept", 16'(stage_cnt), 16'h0007);
        issue(1, {4'd7, 3'd7, 4'd0, 21'd0});
        chk("R3 form 7 illegal", 16'(illegal_o), 16'h1);
        chk("R11 zero kept", 16'(flag_zero), 16'(z));
        chk("R11 ovf kept", 16'(flag_ovf), 16'(v));
        chk("R11 stage kept", 16'(stage_cnt), 16'h0007);
    endtask

    task automatic t_foreign;
        logic z, v;
        z = flag_zero; v = flag_ovf;
        issue(1, {4'd4, w_reg(4, 2, 1, 1)} >> 4 | 32'h4000_0000 | (w_reg(4, 2, 1, 1) & 32'h0FFF_FFFF));
        chk("R2 other opcode no illegal", 16'(illegal_o), 16'h0);
        chk_rf("R2 other opcode no write");
        issue(0, w_reg(4, 2, 1, 1));
        chk_rf("R2 invalid no write");
        issue(0, w_stg(2, 8'h00));
        chk("R2 invalid stage kept", 16'(stage_cnt), 16'h0007);
        chk("R2 zero kept", 16'(flag_zero), 16'(z));
        chk("R2 ovf kept", 16'(flag_ovf), 16'(v));
        chk("R2 no illegal", 16'(illegal_o), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_arith;
        t_logic;
        t_shift;
        t_stage;
        t_illegal;
        t_foreign;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, all requirements incomplete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule